// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of active-high interrupt request lines, chooses the most urgent one and raises one interrupt output toward the processor. When the processor acknowledges, the controller replies with a vector number. The upper bits of that number come from a programmable base register. The lower bits are the index of the chosen line. At the same time it moves the chosen line from "pending" to "in service".

While any line is in service, only a request that strictly outranks every in-service line can raise the interrupt output. This allows a more urgent line to nest inside a less urgent handler, and holds back equal or lower requests. Software closes a handler by writing the non-specific end-of-interrupt command. It can read the in-service bits to find out which line is being handled. It can also read back or reprogram the base vector.

Requests are sampled as levels on every clock. The number of lines must be a power of two so that the line index fills the low vector bits exactly. The register port has a one-bit address: 0 selects the command/status register and 1 selects the base register.

Top module: `pic_ctrl`

## Requirements
- R1: After a synchronous reset, `intr_o` and `vec_valid_o` are 0, no line is in service, and the base register reads 0x08.
- R2: The vector for line n is the base plus n. The base holds only multiples of 8, because a write to address 1 drops data bits 2:0, so vector bits 2:0 always equal the line index.
- R3: Among pending lines, the lowest index wins, and line 0 is the most urgent.
- R4: `intr_o` is high exactly when a sampled request outranks every in-service line. A request seen at a clock edge shows on `intr_o` after the following edge, and `intr_o` drops in the cycle after an acknowledge.
- R5: While a line is in service, requests on that line or on higher-index lines do not raise `intr_o`, but a lower-index request does (nesting).
- R6: When `ack_i` is sampled high with `intr_o`'s condition true, then one cycle later `vec_valid_o` pulses with the vector on `vec_o`, and the winning line's in-service bit is set.
- R7: Writing 0x20 to address 0 clears the lowest-index set in-service bit. Any other value written to address 0 changes nothing.
- R8: A read of address 0 returns the in-service bits (bit n = line n) and a read of address 1 returns the base. In both cases the data appears on `reg_rdata_o` one cycle after `reg_rd_i` and is held until the next read.
- R9: An acknowledge when no request qualifies produces no `vec_valid_o` pulse and leaves the in-service bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Active-high request lines, index 0 most urgent |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | 0 = command/status, 1 = base vector |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number returned for an acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse marking `vec_o` as fresh |

## Verification
Assertions check a set of properties on every cycle. A returned vector always carries the base that was current when it was granted, and its in-service bit is set. No line more urgent than the granted one is still in service. `intr_o` falls after each acknowledge. An end-of-interrupt removes exactly one in-service bit, and a spurious acknowledge never yields a vector. Some behaviour is shown only by the bench's scenarios. These are the absolute vector values, the ordering between competing lines, nesting followed by unwinding through successive end-of-interrupt commands, the ignored command values, the reset contents and the read-back path. All of these are compared against a cycle model under random request, acknowledge and register traffic.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    REG_CMD_STAT = 1'b0,
    REG_BASE     = 1'b1
  } pic_reg_e;

  localparam logic [7:0] CMD_EOI_NONSPEC = 8'h20;
endpackage

// File: rtl/pic_prio_enc.sv
// Lowest-index-first priority encoder.
module pic_prio_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign onehot_o[i]  = vec_i[i] & ~seen[i];
    assign seen[i+1]    = seen[i] | vec_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
// Picks the most urgent pending line and decides whether it outranks
// every in-service line; also finds the most urgent in-service line.
module pic_arbiter #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  isr_i,
  output logic          eligible_o,
  output logic [N-1:0]  cand_oh_o,
  output logic [IW-1:0] cand_idx_o,
  output logic [N-1:0]  isr_low_oh_o
);
  logic [N:0]   isr_clear_below;  // no in-service bit at index < i
  logic [N-1:0] outranks;         // line i beats all in-service lines

  assign isr_clear_below[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign isr_low_oh_o[i]      = isr_i[i] & isr_clear_below[i];
    assign outranks[i]          = ~isr_i[i] & isr_clear_below[i];
    assign isr_clear_below[i+1] = isr_clear_below[i] & ~isr_i[i];
  end

  pic_prio_enc #(.N(N)) u_req_enc (
    .vec_i    (req_i),
    .onehot_o (cand_oh_o),
    .idx_o    (cand_idx_o)
  );

  assign eligible_o = |(cand_oh_o & outranks);
endmodule

// File: rtl/pic_regs.sv
// Base vector register, command decode and registered read-back.
module pic_regs #(
  parameter int VEC_W = 8,
  parameter int N     = 8,
  parameter logic [VEC_W-1:0] BASE_RESET = 8'h08,
  localparam int IW   = $clog2(N),
  localparam int HI_W = VEC_W - IW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [N-1:0]     isr_i,
  output logic [HI_W-1:0]  base_hi_o,
  output logic             eoi_o,
  output logic [VEC_W-1:0] rdata_o
);
  import pic_pkg::*;

  logic [HI_W-1:0]  base_hi_q;
  logic [VEC_W-1:0] rdata_q;

  assign eoi_o = wr_i && (addr_i == REG_CMD_STAT) &&
                 (wdata_i == VEC_W'(CMD_EOI_NONSPEC));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi_q <= BASE_RESET[VEC_W-1:IW];
      rdata_q   <= '0;
    end else begin
      if (wr_i && addr_i == REG_BASE) base_hi_q <= wdata_i[VEC_W-1:IW];
      if (rd_i) begin
        if (addr_i == REG_BASE) rdata_q <= {base_hi_q, {IW{1'b0}}};
        else                    rdata_q <= VEC_W'(isr_i);
      end
    end
  end

  assign base_hi_o = base_hi_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] BASE_RESET = 8'h08,
  localparam int IDX_W = $clog2(N_LINES),
  localparam int HI_W  = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               ack_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic               reg_addr_i,
  input  logic [VEC_W-1:0]   reg_wdata_i,
  output logic [VEC_W-1:0]   reg_rdata_o,
  output logic               intr_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic [N_LINES-1:0] req_q, isr_q;
  logic               intr_q, vv_q;
  logic [VEC_W-1:0]   vec_q;

  logic               eligible, grant, eoi_cmd;
  logic [N_LINES-1:0] cand_oh, isr_low_oh, grant_oh, eoi_oh;
  logic [IDX_W-1:0]   cand_idx;
  logic [HI_W-1:0]    base_hi;

  pic_arbiter #(.N(N_LINES)) u_arb (
    .req_i        (req_q),
    .isr_i        (isr_q),
    .eligible_o   (eligible),
    .cand_oh_o    (cand_oh),
    .cand_idx_o   (cand_idx),
    .isr_low_oh_o (isr_low_oh)
  );

  pic_regs #(.VEC_W(VEC_W), .N(N_LINES), .BASE_RESET(BASE_RESET)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .isr_i     (isr_q),
    .base_hi_o (base_hi),
    .eoi_o     (eoi_cmd),
    .rdata_o   (reg_rdata_o)
  );

  assign grant    = ack_i & eligible;
  assign grant_oh = grant   ? cand_oh    : '0;
  assign eoi_oh   = eoi_cmd ? isr_low_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      isr_q  <= '0;
      intr_q <= 1'b0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      req_q  <= irq_i & ~grant_oh;
      isr_q  <= (isr_q & ~eoi_oh) | grant_oh;
      intr_q <= eligible & ~ack_i;
      vv_q   <= grant;
      if (grant) vec_q <= {base_hi, cand_idx};
    end
  end

  assign intr_o      = intr_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vv_q;

  // ---------------- assertions ----------------
  logic [N_LINES-1:0] more_urgent_mask;
  assign more_urgent_mask = (N_LINES'(1) << vec_q[IDX_W-1:0]) - N_LINES'(1);

  assert_vec_base_R2: assert property (@(posedge clk) disable iff (rst)
    grant |=> vec_o[VEC_W-1:IDX_W] == $past(base_hi));

  assert_isr_set_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> isr_q[vec_o[IDX_W-1:0]]);

  assert_nest_order_R5: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> (isr_q & more_urgent_mask) == '0);

  assert_intr_drop_R4: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !intr_o);

  assert_eoi_single_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_cmd && !grant && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_spurious_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !eligible && !eoi_cmd) |=> (!vec_valid_o && $stable(isr_q)));
endmodule

// File: tb/pic_ctrl_tb.sv
module pic_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_i = '0;
  logic       ack_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0, reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o, vec_o;
  logic       intr_o, vec_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pic_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .ack_i(ack_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .intr_o(intr_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int first_set(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  // ---------------- reference model built from the requirements ----------------
  logic [7:0] m_req, m_isr, m_vec, m_base, m_rdata;
  logic       m_intr, m_vv;

  always @(posedge clk) begin
    int c, t;
    bit elig, grant, eoi;
    logic [7:0] goh, eoh;
    if (rst) begin
      m_req <= '0; m_isr <= '0; m_intr <= 1'b0; m_vv <= 1'b0;
      m_vec <= '0; m_base <= 8'h08; m_rdata <= '0;
    end else begin
      c = first_set(m_req);
      t = first_set(m_isr);
      elig  = (c < 8) && (c < t);
      grant = ack_i && elig;
      eoi   = reg_wr_i && !reg_addr_i && reg_wdata_i == 8'h20;
      goh   = grant ? (8'h01 << c) : 8'h00;
      eoh   = (eoi && t < 8) ? (8'h01 << t) : 8'h00;
      m_req  <= irq_i & ~goh;
      m_isr  <= (m_isr & ~eoh) | goh;
      m_intr <= elig && !ack_i;
      m_vv   <= grant;
      if (grant) m_vec <= m_base + 8'(c);
      if (reg_wr_i && reg_addr_i) m_base <= reg_wdata_i & 8'hF8;
      if (reg_rd_i) m_rdata <= reg_addr_i ? m_base : m_isr;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(intr_o === m_intr, "R4 intr", 32'(intr_o), 32'(m_intr));
      check(vec_valid_o === m_vv, "R6 vec_valid", 32'(vec_valid_o), 32'(m_vv));
      if (m_vv) check(vec_o === m_vec, "R2 vector", 32'(vec_o), 32'(m_vec));
      check(reg_rdata_o === m_rdata, "R8 rdata", 32'(reg_rdata_o), 32'(m_rdata));
    end
  end

  // ---------------- stimulus helpers (drive at negedge) ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic a, output logic [7:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic do_ack(output logic vv, output logic [7:0] v);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    vv = vec_valid_o; v = vec_o;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, v;
    logic vv;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(intr_o === 1'b0, "R1 intr after reset", 32'(intr_o), 0);
    check(vec_valid_o === 1'b0, "R1 vec_valid after reset", 32'(vec_valid_o), 0);
    do_read(1'b1, d); check(d === 8'h08, "R1 base reset", 32'(d), 32'h08);
    do_read(1'b0, d); check(d === 8'h00, "R1 isr reset", 32'(d), 32'h00);

    // R3: lines 2 and 5 together, line 2 wins
    irq_i = 8'b0010_0100;
    wait_cyc(2);
    check(intr_o === 1'b1, "R4 intr raised", 32'(intr_o), 1);
    do_ack(vv, v);
    check(vv === 1'b1 && v === 8'h0A, "R3 lowest line wins", 32'(v), 32'h0A);
    check(intr_o === 1'b0, "R4 intr dropped after ack", 32'(intr_o), 0);
    do_read(1'b0, d); check(d === 8'h04, "R6 isr bit set", 32'(d), 32'h04);

    // R5: lower (line 5) and equal (line 2) held off; line 0 nests
    wait_cyc(3);
    check(intr_o === 1'b0, "R5 lower held off", 32'(intr_o), 0);
    irq_i = 8'b0010_0101;
    wait_cyc(2);
    check(intr_o === 1'b1, "R5 higher nests", 32'(intr_o), 1);
    do_ack(vv, v);
    check(vv === 1'b1 && v === 8'h08, "R2 line 0 base 8 vector", 32'(v), 32'h08);
    irq_i = 8'b0010_0000;
    do_read(1'b0, d); check(d === 8'h05, "R5 nested isr", 32'(d), 32'h05);

    // R9: spurious acknowledge
    wait_cyc(2);
    do_ack(vv, v);
    check(vv === 1'b0, "R9 no vector on spurious ack", 32'(vv), 0);
    do_read(1'b0, d); check(d === 8'h05, "R9 isr unchanged", 32'(d), 32'h05);

    // R7: other command ignored, EOI unwinds most urgent first
    do_write(1'b0, 8'h21);
    do_read(1'b0, d); check(d === 8'h05, "R7 non-EOI ignored", 32'(d), 32'h05);
    do_write(1'b0, 8'h20);
    do_read(1'b0, d); check(d === 8'h04, "R7 EOI clears line 0", 32'(d), 32'h04);
    check(intr_o === 1'b0, "R5 line 5 still below line 2", 32'(intr_o), 0);
    do_write(1'b0, 8'h20);
    do_read(1'b0, d); check(d === 8'h00, "R7 EOI clears line 2", 32'(d), 32'h00);
    wait_cyc(1);
    check(intr_o === 1'b1, "R4 pending line 5 now raises", 32'(intr_o), 1);

    // R2: base alignment and vector
    do_write(1'b1, 8'h6B);
    do_read(1'b1, d); check(d === 8'h68, "R2 base low bits dropped", 32'(d), 32'h68);
    do_ack(vv, v);
    check(vv === 1'b1 && v === 8'h6D, "R2 base plus line 5", 32'(v), 32'h6D);
    irq_i = 8'h00;
    do_write(1'b0, 8'h20);
    wait_cyc(2);

    // random phase, checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      irq_i       = 8'($urandom) & 8'($urandom);
      ack_i       = ($urandom % 4) == 0;
      reg_rd_i    = ($urandom % 3) == 0;
      reg_wr_i    = ($urandom % 6) == 0;
      reg_addr_i  = ($urandom % 5) == 0;
      reg_wdata_i = (($urandom % 4) != 0 && !reg_addr_i) ? 8'h20 : 8'($urandom);
      @(negedge clk);
    end
    ack_i = 0; reg_rd_i = 0; reg_wr_i = 0; irq_i = 0;
    wait_cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule